// File: doc/BRIEF.md
# Strap-Addressed I2C Register Slave

This block is an I2C target that gives a host access to a small bank of byte registers over the two bus wires. It never drives the clock line and never starts a transfer. It pulls the data line low through an output-enable (open drain). It watches a synchronized copy of both wires, recognises START and STOP, shifts in the address byte and the data bytes, and answers with acknowledge bits. It serves reads from a register pointer that steps forward after every byte.

The device address is chosen by a strap input, which is sampled once on the first clock after reset is released. The same pin serves another function afterwards, so any later activity on it is ignored. A host writes the pointer with the first data byte of a write transfer. The bytes that follow fill registers at successive addresses. A repeated START switches to a read without losing the pointer.

Top module: `i2c_strap_slave`

## Requirements
- R1: While reset is high and after it is released, `sda_oe` is 0, and the block ignores the bus until a START arrives.
- R2: The strap is sampled on the first clock after reset is released. A 0 selects the 7-bit address 0x5C (write byte B8h, read byte B9h) and a 1 selects 0x5D (write byte BAh, read byte BBh). The address byte carries the 7-bit address MSB first, then a direction bit (1 = read). A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: A change on the strap after it has been sampled does not change the address the block answers to.
- R4: An address byte that does not match leaves SDA released in its acknowledge slot. The block then acknowledges no byte and writes no register until the next START.
- R5: In a write, the first data byte loads the pointer (its low AW bits). Each later byte is stored at the pointer, and then the pointer increments. Every byte is acknowledged.
- R6: In a read, the register at the pointer is sent MSB first, one bit per clock, and changes only while SCL is low. The pointer increments after each byte and wraps from the last register to 0.
- R7: When the master answers a read byte with NACK (SDA high in the ninth clock), the block releases SDA until the next START.
- R8: A repeated START returns the block to address reception and keeps the pointer.
- R9: A STOP returns the block to idle. The pointer is kept for the next transfer.
- R10: `sda_oe` is high only in the block's own acknowledge slots and for 0 bits of read data. It changes only while SCL is low.
- R11: A transfer has no byte limit. A write longer than the register bank wraps around the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Address-select strap, sampled once after reset |
| sda_oe | output | 1 | Pull data line low when 1 (open drain) |

## Verification
Writes are tried with a single pointer byte, with short bursts, and with a burst longer than the bank. These tell a correctly loaded pointer apart from wrap errors in the increment. Reads are tried after a STOP, after a repeated START, and across the last-to-first register boundary. These show whether the pointer survives each kind of transfer boundary. Address bytes are tried with the own address, with the other strap address, and with an unrelated address, both before and after a strap change and across a second reset with the opposite strap level. Together these separate the address that was latched from the pin's live level. A bench model predicts `sda_oe` for every quiet clock, which exposes any drive outside acknowledge slots and read bits.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  // one extra stage holds the previous synchronized value for edge detection
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] scl_q;
  logic [LEN-1:0] sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[LEN-2:0], scl_i};
      sda_q <= {sda_q[LEN-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now = scl_q[STAGES-1];
  assign scl_old = scl_q[STAGES];
  assign sda_s   = sda_q[STAGES-1];
  assign sda_old = sda_q[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        dev_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic [AW-1:0]     ptr,
  output logic              idle
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  slv_state_t        st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] rd_sh;
  logic              rw;
  logic              first;
  logic              mack;

  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      rd_sh  <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
      ptr    <= '0;
    end else begin
      we <= 1'b0;
      if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise && cnt < FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (sh[BYTE_W-1:1] == dev_addr) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                rd_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                first  <= 1'b1;
                st     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && cnt < FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt    <= '0;
              sda_oe <= 1'b1;
              st     <= ST_WR_ACK;
              if (first) begin
                ptr   <= sh[AW-1:0];
                first <= 1'b0;
              end else begin
                we    <= 1'b1;
                waddr <= ptr;
                wdata <= sh;
                ptr   <= ptr + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                st     <= ST_RD_ACK;
              end else begin
                rd_sh  <= rd_sh << 1;
                sda_oe <= ~rd_sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                rd_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                st     <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_slv_pkg::*;
#(
  parameter int         AW          = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h5C,
  parameter logic [6:0] ADDR_HI     = 7'h5D
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic sda_oe
);
  logic sel_valid, addr_sel;
  logic [6:0] dev_addr;

  // strap is captured once, then the pin belongs to another function
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      addr_sel  <= 1'b0;
    end else if (!sel_valid) begin
      sel_valid <= 1'b1;
      addr_sel  <= strap_i;
    end
  end

  assign dev_addr = addr_sel ? ADDR_HI : ADDR_LO;

  logic sda_s, scl_rise, scl_fall, start_raw, stop_evt, start_go;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_raw),
    .stop_evt  (stop_evt)
  );

  assign start_go = start_raw & sel_valid;

  logic              reg_we, fsm_idle;
  logic [AW-1:0]     reg_waddr, ptr;
  logic [BYTE_W-1:0] reg_wdata, reg_rdata;

  i2c_slave_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .dev_addr  (dev_addr),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_go),
    .stop_evt  (stop_evt),
    .rd_data   (reg_rdata),
    .sda_oe    (sda_oe),
    .we        (reg_we),
    .waddr     (reg_waddr),
    .wdata     (reg_wdata),
    .ptr       (ptr),
    .idle      (fsm_idle)
  );

  i2c_regbank #(.AW(AW), .DW(BYTE_W)) u_regs (
    .clk   (clk),
    .we    (reg_we),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .raddr (ptr),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          sel_valid,
  input logic          addr_sel,
  input logic          start_go,
  input logic [AW-1:0] ptr,
  input logic          fsm_idle
);
  // R1
  reset_release_chk: assert property (@(posedge clk) rst |=> !sda_oe);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && $past(sel_valid)) |-> $stable(addr_sel));

  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    fsm_idle |-> !sda_oe);

  // R8
  ptr_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_go |=> $stable(ptr));
endmodule

bind i2c_strap_slave i2c_strap_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .sel_valid (sel_valid),
  .addr_sel  (addr_sel),
  .start_go  (start_go),
  .ptr       (ptr),
  .fsm_idle  (fsm_idle)
);

// File: tb/i2c_strap_slave_bench.sv
`timescale 1ns/1ps
module i2c_strap_slave_bench;
  localparam int Q    = 16;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b1;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_strap_slave u_i2c_strap_slave (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .strap_i (strap),
    .sda_oe  (sda_oe)
  );

  int checks = 0;
  int errors = 0;
  bit dc = 1'b0;
  bit exp_oe = 1'b0;
  logic [7:0] ref_mem [NREG];
  int ref_ptr = 0;
  logic [6:0] my_addr;
  logic [7:0] wq [$];

  // every quiet clock: output-enable versus model (R10)
  always @(posedge clk) begin
    #1;
    if (!rst && !dc) begin
      checks++;
      if (sda_oe !== exp_oe) begin
        errors++;
        $display("FAIL R10 sda_oe actual %0b expected %0b at %0t", sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slot(input bit mb, input bit e, output bit seen);
    sda_m = mb;
    wait_n(Q);
    exp_oe = e;
    dc = 1'b0;
    wait_n(Q);
    scl = 1'b1;
    wait_n(Q);
    seen = sda_line;
    wait_n(Q);
    dc = 1'b1;
    scl = 1'b0;
  endtask

  task automatic start_c();
    dc = 1'b1;
    sda_m = 1'b1;
    wait_n(Q);
    exp_oe = 1'b0;
    dc = 1'b0;
    scl = 1'b1;
    wait_n(2*Q);
    sda_m = 1'b0;
    wait_n(2*Q);
    dc = 1'b1;
    scl = 1'b0;
  endtask

  task automatic stop_c();
    dc = 1'b1;
    sda_m = 1'b0;
    wait_n(Q);
    exp_oe = 1'b0;
    dc = 1'b0;
    scl = 1'b1;
    wait_n(2*Q);
    sda_m = 1'b1;
    wait_n(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, s);
    slot(1'b1, ack, s);
    check(s == !ack, req, s, !ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    bit s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, ~exp[i], s);
      got[i] = s;
    end
    check(got == exp, req, got, exp);
    slot(!mack, 1'b0, s);
  endtask

  task automatic do_write(input logic [6:0] a, input bit do_stop, input string req);
    bit match;
    match = (a == my_addr);
    start_c();
    send_byte({a, 1'b0}, match, req);
    if (!match) begin
      send_byte(8'h5A, 1'b0, "R4");
      stop_c();
      return;
    end
    for (int i = 0; i < wq.size(); i++) begin
      send_byte(wq[i], 1'b1, req);
      if (i == 0) ref_ptr = wq[i] % NREG;
      else begin
        ref_mem[ref_ptr] = wq[i];
        ref_ptr = (ref_ptr + 1) % NREG;
      end
    end
    if (do_stop) stop_c();
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    bit match;
    bit s;
    match = (a == my_addr);
    start_c();
    send_byte({a, 1'b1}, match, req);
    if (!match) begin
      stop_c();
      return;
    end
    for (int i = 0; i < n; i++) begin
      recv_byte(ref_mem[ref_ptr], i < n - 1, req);
      ref_ptr = (ref_ptr + 1) % NREG;
    end
    // R7: after the master NACK an extra clock sees a released line
    slot(1'b1, 1'b0, s);
    check(s == 1'b1, "R7", s, 1);
    stop_c();
  endtask

  task automatic do_reset(input bit lvl);
    strap = lvl;
    rst = 1'b1;
    wait_n(6);
    rst = 1'b0;
    my_addr = lvl ? 7'h5D : 7'h5C;
    ref_ptr = 0;
    wait_n(3);
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(2);
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    do_reset(1'b1);
    strap = 1'b0; // R3: pin reused after sampling

    // R5 R11: pointer 0 then 20 bytes, wrapping the bank
    wq.delete();
    wq.push_back(8'h00);
    for (int i = 0; i < 20; i++) wq.push_back(8'((i * 37 + 5) & 8'hFF));
    do_write(7'h5D, 1'b1, "R11");
    do_read(7'h5D, 16, "R6");

    // R3: the other strap address is not answered after the pin moves
    wq.delete();
    wq.push_back(8'h02);
    wq.push_back(8'hEE);
    do_write(7'h5C, 1'b1, "R3");
    // R4: an unrelated address
    do_write(7'h21, 1'b1, "R4");
    do_read(7'h5C, 1, "R3");
    wq.delete();
    wq.push_back(8'h02);
    do_write(7'h5D, 1'b1, "R4");
    do_read(7'h5D, 2, "R4");

    // R8: repeated START keeps the pointer, read wraps 14,15,0,1 (R6)
    wq.delete();
    wq.push_back(8'h0E);
    do_write(7'h5D, 1'b0, "R8");
    do_read(7'h5D, 4, "R8");
    // R9: after STOP the pointer continues
    do_read(7'h5D, 2, "R9");

    // R5: short burst, then pointer-only write and read back
    wq.delete();
    wq.push_back(8'h93);
    wq.push_back(8'hA5);
    wq.push_back(8'h3C);
    do_write(7'h5D, 1'b1, "R5");
    wq.delete();
    wq.push_back(8'h03);
    do_write(7'h5D, 1'b0, "R5");
    do_read(7'h5D, 2, "R5");

    // R2: second reset with the strap low
    do_reset(1'b0);
    strap = 1'b1;
    do_read(7'h5D, 1, "R2");
    do_read(7'h5C, 3, "R2");
    wq.delete();
    wq.push_back(8'h07);
    wq.push_back(8'hFF);
    wq.push_back(8'h00);
    do_write(7'h5C, 1'b1, "R2");
    wq.delete();
    wq.push_back(8'h06);
    do_write(7'h5C, 1'b0, "R2");
    do_read(7'h5C, 4, "R2");

    wait_n(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule